// File: doc/BRIEF.md
# Per-Thread Dual Program Counter with Interrupt Swap

This block keeps the program-counter state for a fixed set of hardware threads. Every thread owns two address registers: a live register that drives the thread's fetch address, and a shadow register. While the thread runs background code, the shadow holds the entry address of the thread's next interrupt handler. While the handler runs, the shadow holds the address where background code resumes.

Entering or leaving interrupt level exchanges the two registers in one clock cycle. No return address is pushed or popped, and no instruction is spent on the change. Each cycle, the block also takes redirect targets (branch, jump, call) and sequential advance requests for each thread. It reports each thread's fetch address and interrupt-level flag.

The surrounding pipeline chooses when each thread advances or redirects, and an external controller decides when a thread enters or leaves interrupt level. Software loads the handler entry address through a per-thread shadow write port.

Top module: `thread_pc_swap`

## Requirements
- R1: After reset, every thread's fetch address is RESET_PC (default 0) and its level flag is 0 (background). Every shadow register holds RESET_SHADOW (default 0x100), which becomes visible on the first interrupt entry.
- R2: When a thread has a sequential advance request and no redirect or swap, its fetch address grows by STEP (default 4) on the next cycle. With no request at all, the address holds.
- R3: An entry request at background level has the following effect on the next cycle: the fetch address becomes the former shadow value, the shadow takes the former live address, and the level flag reads 1.
- R4: An exit request at interrupt level exchanges the two registers again and clears the level flag. Background execution then resumes at the saved address.
- R5: A redirect loads the live register with the exact target, including its low bits, with no offset applied. A redirect takes priority over a sequential advance in the same cycle.
- R6: An entry request at interrupt level does not swap and does not change the level. An exit request at background level is treated the same way. An advance or redirect in that cycle still acts on the live register.
- R7: When a swap occurs in the same cycle as a redirect (or an advance), the swap wins. The redirect target (or the advanced address) is written into the register that becomes the shadow.
- R8: A shadow write is accepted only at background level when no swap occurs in the same cycle. At interrupt level, or together with an entry, the write is dropped.
- R9: Each thread's registers and level flag change only on that thread's own requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_adv | input | NUM_THREADS | Per-thread sequential advance request |
| br_valid | input | NUM_THREADS | Per-thread redirect (branch/jump/call) strobe |
| br_target | input | NUM_THREADS x ADDR_W | Per-thread redirect target address |
| irq_enter | input | NUM_THREADS | Per-thread interrupt entry request |
| irq_exit | input | NUM_THREADS | Per-thread interrupt return request |
| shadow_wr | input | NUM_THREADS | Per-thread shadow register write strobe |
| shadow_wdata | input | NUM_THREADS x ADDR_W | Per-thread shadow write data |
| fetch_pc | output | NUM_THREADS x ADDR_W | Per-thread current fetch address |
| irq_level | output | NUM_THREADS | Per-thread interrupt-level flag |

## Verification
The assertions only assume that the request strobes are well defined once reset is released. They assume nothing about the order or overlap of requests, so entry and exit may arrive together, and a redirect, an advance and a shadow write may all coincide with a swap. The stimulus changes inputs a nanosecond after each rising edge and holds them for a full cycle. It deliberately sends entries at interrupt level, exits at background, and shadow writes that collide with a swap, so the priority rules are exercised rather than avoided.

// File: rtl/pcswap_pkg.sv
`timescale 1ns/1ps
package pcswap_pkg;

   typedef enum logic [1:0] {
      LVL_OP_NONE  = 2'd0,
      LVL_OP_ENTER = 2'd1,
      LVL_OP_EXIT  = 2'd2
   } lvl_op_e;

   // Decide which level transition is legal this cycle.
   function automatic lvl_op_e decode_lvl_op(input logic at_irq,
                                             input logic enter_req,
                                             input logic exit_req);
      lvl_op_e op;
      op = LVL_OP_NONE;
      if (at_irq && exit_req)
         op = LVL_OP_EXIT;
      else if (!at_irq && enter_req)
         op = LVL_OP_ENTER;
      return op;
   endfunction

endpackage

// File: rtl/pc_seq_step.sv
`timescale 1ns/1ps
module pc_seq_step #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] pc_o
);
   localparam int unsigned STEP_LOG2 = $clog2(STEP);
   localparam bit          STEP_POW2 = (STEP == (1 << STEP_LOG2));

   generate
      if (STEP_POW2 && (STEP_LOG2 > 0) && (STEP_LOG2 < ADDR_W)) begin : g_upper_inc
         // Power-of-two step: increment only the bits above the step size.
         localparam logic [ADDR_W-STEP_LOG2-1:0] UP_ONE = 1;
         assign pc_o = {pc_i[ADDR_W-1:STEP_LOG2] + UP_ONE, pc_i[STEP_LOG2-1:0]};
      end else begin : g_full_add
         localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
         assign pc_o = pc_i + STEP_V;
      end
   endgenerate
endmodule

// File: rtl/pc_level_ctrl.sv
`timescale 1ns/1ps
module pc_level_ctrl
   import pcswap_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    enter_req,
   input  logic    exit_req,
   output lvl_op_e op_o,
   output logic    level_o
);
   logic level_q;

   always_comb op_o = decode_lvl_op(level_q, enter_req, exit_req);

   always_ff @(posedge clk) begin
      if (!rst_n)
         level_q <= 1'b0;
      else if (op_o == LVL_OP_ENTER)
         level_q <= 1'b1;
      else if (op_o == LVL_OP_EXIT)
         level_q <= 1'b0;
   end

   assign level_o = level_q;

   // R6: an entry request while already at interrupt level leaves the level unchanged.
   a_r6_enter_at_irq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q && !exit_req) |=> level_q);
   // R6: an exit request at background level leaves the level unchanged.
   a_r6_exit_at_bg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_q && !enter_req) |=> !level_q);
   // R3/R4: a legal request always flips the level.
   a_r3_level_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o != LVL_OP_NONE) |=> (level_q != $past(level_q)));
endmodule

// File: rtl/pc_thread_slot.sv
`timescale 1ns/1ps
module pc_thread_slot
   import pcswap_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 32,
   parameter int unsigned       STEP         = 4,
   parameter logic [ADDR_W-1:0] RESET_PC     = '0,
   parameter logic [ADDR_W-1:0] RESET_SHADOW = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_adv,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              irq_enter,
   input  logic              irq_exit,
   input  logic              shadow_wr,
   input  logic [ADDR_W-1:0] shadow_wdata,
   output logic [ADDR_W-1:0] pc_o,
   output logic              level_o
);
   logic [ADDR_W-1:0] pc_q, pcx_q, pc_inc, flow_pc;
   lvl_op_e           op;
   logic              level;
   logic              swap;

   pc_level_ctrl u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter_req (irq_enter),
      .exit_req  (irq_exit),
      .op_o      (op),
      .level_o   (level)
   );

   pc_seq_step #(.ADDR_W(ADDR_W), .STEP(STEP)) u_step (
      .pc_i (pc_q),
      .pc_o (pc_inc)
   );

   assign swap = (op != LVL_OP_NONE);

   // Address the thread's own flow would reach this cycle.
   always_comb begin
      if (br_valid)
         flow_pc = br_target;
      else if (seq_adv)
         flow_pc = pc_inc;
      else
         flow_pc = pc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         pcx_q <= RESET_SHADOW;
      end else if (swap) begin
         pc_q  <= pcx_q;
         pcx_q <= flow_pc;
      end else begin
         pc_q <= flow_pc;
         if (shadow_wr && !level)
            pcx_q <= shadow_wdata;
      end
   end

   assign pc_o    = pc_q;
   assign level_o = level;

   // R3: entry brings the former shadow into the live register.
   a_r3_entry_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      (op == LVL_OP_ENTER) |=> (pc_q == $past(pcx_q)) && level);
   // R4: exit restores the saved background address.
   a_r4_exit_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (op == LVL_OP_EXIT) |=> (pc_q == $past(pcx_q)) && !level);
   // R5: a redirect without a swap loads the exact target.
   a_r5_target_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !swap) |=> (pc_q == $past(br_target)));
   // R7: a redirect that coincides with a swap lands in the shadow.
   a_r7_target_to_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && swap) |=> (pcx_q == $past(br_target)));
   // R2: with no request the live register holds.
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !seq_adv && !swap) |=> $stable(pc_q));
   // R8: the shadow is frozen at interrupt level unless an exit occurs.
   a_r8_shadow_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (level && !irq_exit) |=> $stable(pcx_q));
endmodule

// File: rtl/thread_pc_swap.sv
`timescale 1ns/1ps
module thread_pc_swap #(
   parameter int unsigned       NUM_THREADS  = 4,
   parameter int unsigned       ADDR_W       = 32,
   parameter int unsigned       STEP         = 4,
   parameter logic [ADDR_W-1:0] RESET_PC     = '0,
   parameter logic [ADDR_W-1:0] RESET_SHADOW = ADDR_W'(32'h100)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_THREADS-1:0]            seq_adv,
   input  logic [NUM_THREADS-1:0]            br_valid,
   input  logic [NUM_THREADS-1:0][ADDR_W-1:0] br_target,
   input  logic [NUM_THREADS-1:0]            irq_enter,
   input  logic [NUM_THREADS-1:0]            irq_exit,
   input  logic [NUM_THREADS-1:0]            shadow_wr,
   input  logic [NUM_THREADS-1:0][ADDR_W-1:0] shadow_wdata,
   output logic [NUM_THREADS-1:0][ADDR_W-1:0] fetch_pc,
   output logic [NUM_THREADS-1:0]            irq_level
);
   localparam int unsigned STEP_LOG2 = $clog2(STEP);

   generate
      if (NUM_THREADS < 1 || NUM_THREADS > 16) begin : g_bad_threads
         $error("thread_pc_swap: NUM_THREADS must be 1..16");
      end
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_width
         $error("thread_pc_swap: ADDR_W must be 4..64");
      end
      if (STEP < 1 || STEP_LOG2 >= ADDR_W) begin : g_bad_step
         $error("thread_pc_swap: STEP must be nonzero and below 2**ADDR_W");
      end

      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
         pc_thread_slot #(
            .ADDR_W       (ADDR_W),
            .STEP         (STEP),
            .RESET_PC     (RESET_PC),
            .RESET_SHADOW (RESET_SHADOW)
         ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .seq_adv      (seq_adv[t]),
            .br_valid     (br_valid[t]),
            .br_target    (br_target[t]),
            .irq_enter    (irq_enter[t]),
            .irq_exit     (irq_exit[t]),
            .shadow_wr    (shadow_wr[t]),
            .shadow_wdata (shadow_wdata[t]),
            .pc_o         (fetch_pc[t]),
            .level_o      (irq_level[t])
         );

         // R9: with no request of its own, a thread's outputs do not move.
         a_r9_thread_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (!seq_adv[t] && !br_valid[t] && !irq_enter[t] && !irq_exit[t])
            |=> $stable(fetch_pc[t]) && $stable(irq_level[t]));
      end
   endgenerate
endmodule

// File: tb/tb_thread_pc_swap.sv
`timescale 1ns/1ps
module tb_thread_pc_swap;
   localparam int NT = 4;
   localparam int AW = 32;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic [NT-1:0]         seq_adv, br_valid, irq_enter, irq_exit, shadow_wr;
   logic [NT-1:0][AW-1:0] br_target, shadow_wdata;
   logic [NT-1:0][AW-1:0] fetch_pc;
   logic [NT-1:0]         irq_level;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   thread_pc_swap dut (
      .clk, .rst_n, .seq_adv, .br_valid, .br_target, .irq_enter, .irq_exit,
      .shadow_wr, .shadow_wdata, .fetch_pc, .irq_level
   );

   task automatic idle_inputs();
      seq_adv = '0; br_valid = '0; irq_enter = '0; irq_exit = '0; shadow_wr = '0;
      br_target = '0; shadow_wdata = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      idle_inputs();
   endtask

   task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic t_reset();
      for (int t = 0; t < NT; t++) begin
         chk("R1 fetch", fetch_pc[t], 32'h0);
         chk("R1 level", {31'b0, irq_level[t]}, 32'h0);
      end
   endtask

   task automatic t_sequential();
      for (int i = 0; i < 3; i++) begin
         seq_adv[0] = 1'b1;
         tick();
      end
      chk("R2 advance", fetch_pc[0], 32'hC);
      tick();
      chk("R2 hold", fetch_pc[0], 32'hC);
   endtask

   task automatic t_redirect();
      br_valid[0] = 1'b1; br_target[0] = 32'h2002; seq_adv[0] = 1'b1;
      tick();
      chk("R5 exact target", fetch_pc[0], 32'h2002);
   endtask

   task automatic t_enter_exit();
      seq_adv[1] = 1'b1;
      tick();
      chk("R2 thread1", fetch_pc[1], 32'h4);
      irq_enter[1] = 1'b1;
      tick();
      chk("R3 handler addr", fetch_pc[1], 32'h100);
      chk("R3 level set", {31'b0, irq_level[1]}, 32'h1);
      chk("R9 thread0 untouched", fetch_pc[0], 32'h2002);
      chk("R9 thread0 level", {31'b0, irq_level[0]}, 32'h0);
      irq_enter[1] = 1'b1; seq_adv[1] = 1'b1;
      tick();
      chk("R6 nested entry no swap", fetch_pc[1], 32'h104);
      chk("R6 level kept", {31'b0, irq_level[1]}, 32'h1);
      irq_exit[1] = 1'b1;
      tick();
      chk("R4 resume addr", fetch_pc[1], 32'h4);
      chk("R4 level clear", {31'b0, irq_level[1]}, 32'h0);
      irq_exit[1] = 1'b1;
      tick();
      chk("R6 stray exit", fetch_pc[1], 32'h4);
      chk("R6 stray exit level", {31'b0, irq_level[1]}, 32'h0);
      irq_enter[1] = 1'b1;
      tick();
      chk("R3 handler continues", fetch_pc[1], 32'h104);
   endtask

   task automatic t_enter_with_branch();
      shadow_wr[2] = 1'b1; shadow_wdata[2] = 32'h300;
      tick();
      chk("R8 write no fetch effect", fetch_pc[2], 32'h0);
      irq_enter[2] = 1'b1; br_valid[2] = 1'b1; br_target[2] = 32'h5000;
      tick();
      chk("R7 entry wins", fetch_pc[2], 32'h300);
      chk("R7 level set", {31'b0, irq_level[2]}, 32'h1);
      irq_exit[2] = 1'b1;
      tick();
      chk("R7 target in shadow", fetch_pc[2], 32'h5000);
   endtask

   task automatic t_shadow_blocked();
      irq_enter[3] = 1'b1;
      tick();
      chk("R3 thread3 entry", fetch_pc[3], 32'h100);
      shadow_wr[3] = 1'b1; shadow_wdata[3] = 32'h999;
      tick();
      irq_exit[3] = 1'b1;
      tick();
      chk("R8 exit after blocked write", fetch_pc[3], 32'h0);
      irq_enter[3] = 1'b1;
      tick();
      chk("R8 irq-level write dropped", fetch_pc[3], 32'h100);
      irq_exit[3] = 1'b1;
      tick();
      shadow_wr[3] = 1'b1; shadow_wdata[3] = 32'h700; irq_enter[3] = 1'b1;
      tick();
      chk("R8 write with entry", fetch_pc[3], 32'h100);
      irq_exit[3] = 1'b1;
      tick();
      irq_enter[3] = 1'b1;
      tick();
      chk("R8 colliding write dropped", fetch_pc[3], 32'h100);
   endtask

   initial begin
      #20000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_sequential();
      t_redirect();
      t_enter_exit();
      t_enter_with_branch();
      t_shadow_blocked();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule